// File: doc/BRIEF.md
# Switch-on-Miss Thread Controller

This block steers a single in-order pipeline that carries two hardware thread contexts. Software sees two slower virtual processors, and each has its own program counter. One thread keeps the pipeline until it takes a long-latency cache miss. The controller then flushes the pipeline for a fixed penalty of `FLUSH_CYCLES` cycles (4 by default). It records the faulting instruction's PC in that thread's context, and it points fetch at the PC that the other context saved. A flush is used instead of a drain, so that no instruction in flight survives the switch. This keeps the handling of exceptions simple.

Each context is in one of three states: running, waiting for its miss to return, or ready. A switch can only select a ready context. When no context is ready at the end of a flush, the controller raises a stall. It resumes whichever context's miss returns first. A miss reported while a switch is already under way belongs to an instruction that the flush discards, so the controller ignores it. Reset is synchronous and active low. It loads both contexts with the start PC, makes thread 0 the running thread and makes thread 1 ready.

Top module: `thread_switch_top`

## Requirements
- R1: During and right after reset, `activeTid` is 0 and `flush`, `stall` and `redirectValid` are all 0. Both contexts hold `startPc`, so the first switch to thread 1 redirects to `startPc`.
- R2: A miss seen while a thread runs makes `flush` high from the next cycle on, for exactly `FLUSH_CYCLES` consecutive cycles.
- R3: `redirectValid` is never high while `flush` is high. When the target is ready, `redirectValid` is high for exactly one cycle, the cycle right after the last flush cycle. In that cycle `activeTid` already names the target and `redirectPc` holds the target's saved PC.
- R4: The `missPc` that goes with an accepted miss is stored in the missing thread's context. When that thread resumes later, `redirectPc` equals that PC.
- R5: The target is chosen in this order. First comes the other thread, if it is ready. Next comes the missing thread itself, if its return arrived before or during the last flush cycle. If neither is ready, the controller stalls.
- R6: `stall` is high from the cycle after the last flush cycle for as long as no thread is ready. A return that arrives in cycle r lowers `stall` and produces the redirect in cycle r+1.
- R7: If both returns arrive in the same stalled cycle, the controller resumes the thread that did not take the most recent miss.
- R8: A miss during flush, redirect or stall is ignored. It starts no new flush and does not overwrite any saved PC.
- R9: A return for a thread that is not waiting (bit i of `missRet` is thread i) has no effect at the ports.
- R10: `activeTid` keeps the old thread through the flush and stall cycles. It changes only together with `redirectValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| startPc | input | PC_W | PC loaded into both contexts during reset |
| missValid | input | 1 | The running thread took a long-latency miss this cycle |
| missPc | input | PC_W | PC of the faulting instruction, valid with missValid |
| missRet | input | 2 | Bit i: the pending miss of thread i has returned |
| flush | output | 1 | Discard all instructions in the pipeline |
| redirectValid | output | 1 | Fetch must restart at redirectPc this cycle |
| redirectPc | output | PC_W | Saved PC of the thread being resumed |
| activeTid | output | 1 | Thread that owns the pipeline |
| stall | output | 1 | No thread can run; hold fetch |

## Verification
The bench goes after three corner cases. The first is the exact cycle of the one-cycle redirect: a design that is off by one in its flush count would redirect during the flush or one cycle late. The second is the choice of target when the other thread is still waiting. A design that ignores a return arriving during the flush would stall needlessly. A design with the wrong tie-break would resume the thread that just missed when both returns coincide. The third is a stray miss during the flush or the redirect. A design that accepted it would flush a second time, and it would later resume the thread at the discarded instruction's PC rather than at the real faulting PC.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  typedef enum logic [1:0] {
    TS_READY = 2'd0,
    TS_WAIT  = 2'd1,
    TS_RUN   = 2'd2
  } thrState_t;

  typedef enum logic [1:0] {
    C_RUN   = 2'd0,
    C_FLUSH = 2'd1,
    C_REDIR = 2'd2,
    C_STALL = 2'd3
  } ctlState_t;

  // strobes from control to the context datapath
  typedef struct packed {
    logic saveEn;   // capture the faulting PC
    logic saveTid;  // context that captures it
    logic selTid;   // context driven onto redirectPc
  } dpStrobe_t;

endpackage

// File: rtl/tsw_ctx_dp.sv
module tsw_ctx_dp
  import tsw_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] startPc,
  input  logic [PC_W-1:0] missPc,
  input  dpStrobe_t       dpStb,
  output logic [PC_W-1:0] redirectPc
);

  localparam int NUM_CTX = 2;

  logic [PC_W-1:0] ctxPc [NUM_CTX];

  for (genvar t = 0; t < NUM_CTX; t++) begin : g_ctx
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctxPc[t] <= startPc;
      end else if (dpStb.saveEn && (dpStb.saveTid == 1'(t))) begin
        ctxPc[t] <= missPc;
      end
    end
  end

  assign redirectPc = ctxPc[dpStb.selTid];

endmodule

// File: rtl/tsw_ctrl.sv
module tsw_ctrl
  import tsw_pkg::*;
#(
  parameter int FLUSH_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       missValid,
  input  logic [1:0] missRet,
  output dpStrobe_t  dpStb,
  output logic       flush,
  output logic       redirectValid,
  output logic       stall,
  output logic       activeTid
);

  localparam int NUM_CTX = 2;
  localparam int CNT_W   = $clog2(FLUSH_CYCLES + 1);

  ctlState_t        ctlState, ctlNext;
  thrState_t        thrState [NUM_CTX];
  logic [CNT_W-1:0] flushCnt;
  logic             lastMissTid;
  logic [1:0]       readyNow;
  logic             missTake, decide, pickFound, pickTid, goRedir, preferTid;

  // a waiting context whose return arrives this cycle counts as ready
  for (genvar t = 0; t < NUM_CTX; t++) begin : g_ready
    assign readyNow[t] = (thrState[t] == TS_READY) ||
                         ((thrState[t] == TS_WAIT) && missRet[t]);
  end

  assign missTake  = (ctlState == C_RUN) && missValid;
  assign decide    = ((ctlState == C_FLUSH) && (flushCnt == '0)) || (ctlState == C_STALL);
  assign preferTid = ~lastMissTid;

  always_comb begin
    pickFound = 1'b1;
    pickTid   = preferTid;
    if (readyNow[preferTid]) begin
      pickTid = preferTid;
    end else if (readyNow[lastMissTid]) begin
      pickTid = lastMissTid;
    end else begin
      pickFound = 1'b0;
    end
  end

  assign goRedir = decide && pickFound;

  always_comb begin
    ctlNext = ctlState;
    unique case (ctlState)
      C_RUN:   if (missValid) ctlNext = C_FLUSH;
      C_FLUSH: if (flushCnt == '0) ctlNext = pickFound ? C_REDIR : C_STALL;
      C_STALL: if (pickFound) ctlNext = C_REDIR;
      C_REDIR: ctlNext = C_RUN;
      default: ctlNext = C_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctlState    <= C_RUN;
      flushCnt    <= '0;
      activeTid   <= 1'b0;
      lastMissTid <= 1'b1;
    end else begin
      ctlState <= ctlNext;
      if (missTake) begin
        flushCnt    <= CNT_W'(FLUSH_CYCLES - 1);
        lastMissTid <= activeTid;
      end else if ((ctlState == C_FLUSH) && (flushCnt != '0)) begin
        flushCnt <= flushCnt - 1'b1;
      end
      if (goRedir) activeTid <= pickTid;
    end
  end

  for (genvar t = 0; t < NUM_CTX; t++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        thrState[t] <= (t == 0) ? TS_RUN : TS_READY;
      end else if (missTake && (activeTid == 1'(t))) begin
        thrState[t] <= TS_WAIT;
      end else if (goRedir && (pickTid == 1'(t))) begin
        thrState[t] <= TS_RUN;
      end else if ((thrState[t] == TS_WAIT) && missRet[t]) begin
        thrState[t] <= TS_READY;
      end
    end
  end

  assign flush         = (ctlState == C_FLUSH);
  assign redirectValid = (ctlState == C_REDIR);
  assign stall         = (ctlState == C_STALL);

  assign dpStb.saveEn  = missTake;
  assign dpStb.saveTid = activeTid;
  assign dpStb.selTid  = activeTid;

  // R2: an accepted miss opens a flush on the next cycle
  a_r2_miss_opens_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlState == C_RUN && missValid) |=> flush);

  // R2: the flush window never exceeds its length
  a_r2_flush_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (flushCnt < CNT_W'(FLUSH_CYCLES)));

  // R3: leaving the flush lands directly in a redirect or a stall
  a_r3_flush_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush) |-> (redirectValid || stall));

  // R3: the redirect target is the context marked running
  a_r3_target_runs: assert property (@(posedge clk) disable iff (!rst_n)
    redirectValid |-> (thrState[activeTid] == TS_RUN));

  // R1: at most one context runs at any time
  a_r1_single_runner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({thrState[1] == TS_RUN, thrState[0] == TS_RUN}));

  // R6: a stall only happens while both contexts wait
  a_r6_stall_all_wait: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (thrState[0] == TS_WAIT && thrState[1] == TS_WAIT));

endmodule

// File: rtl/thread_switch_top.sv
module thread_switch_top
  import tsw_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int FLUSH_CYCLES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] startPc,
  input  logic            missValid,
  input  logic [PC_W-1:0] missPc,
  input  logic [1:0]      missRet,
  output logic            flush,
  output logic            redirectValid,
  output logic [PC_W-1:0] redirectPc,
  output logic            activeTid,
  output logic            stall
);

  dpStrobe_t dpStb;

  tsw_ctrl #(.FLUSH_CYCLES(FLUSH_CYCLES)) ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .missValid     (missValid),
    .missRet       (missRet),
    .dpStb         (dpStb),
    .flush         (flush),
    .redirectValid (redirectValid),
    .stall         (stall),
    .activeTid     (activeTid)
  );

  tsw_ctx_dp #(.PC_W(PC_W)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .startPc    (startPc),
    .missPc     (missPc),
    .dpStb      (dpStb),
    .redirectPc (redirectPc)
  );

endmodule

// File: tb/thread_switch_top_tb_top.sv
module thread_switch_top_tb_top;

  localparam int PC_W  = 32;
  localparam int FLUSH = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [PC_W-1:0] startPc;
  logic            missValid;
  logic [PC_W-1:0] missPc;
  logic [1:0]      missRet;
  logic            flush, redirectValid, activeTid, stall;
  logic [PC_W-1:0] redirectPc;

  int nChecks = 0;
  int nErrors = 0;

  always #5 clk = ~clk;

  thread_switch_top #(.PC_W(PC_W), .FLUSH_CYCLES(FLUSH)) dut_i (
    .clk(clk), .rst_n(rst_n), .startPc(startPc), .missValid(missValid),
    .missPc(missPc), .missRet(missRet), .flush(flush),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .activeTid(activeTid), .stall(stall)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic doMiss(input logic [PC_W-1:0] pc);
    missValid = 1'b1;
    missPc    = pc;
    step();
    missValid = 1'b0;
  endtask

  task automatic pulseRet(input logic [1:0] r);
    missRet = r;
    step();
    missRet = 2'b00;
  endtask

  // checks the flush window; optional return or stray miss injected at given index
  task automatic flushPhase(input logic tid, input int retAt, input logic [1:0] retVal,
                            input int missAt, input logic [PC_W-1:0] strayPc);
    for (int i = 0; i < FLUSH; i++) begin
      chk("R2 flush high", flush, 1);
      chk("R3 no redirect in flush", redirectValid, 0);
      chk("R10 tid held in flush", activeTid, tid);
      if (i == retAt) missRet = retVal;
      if (i == missAt) begin missValid = 1'b1; missPc = strayPc; end
      step();
      missRet   = 2'b00;
      missValid = 1'b0;
    end
  endtask

  task automatic checkRedir(input string req, input logic tid, input logic [PC_W-1:0] pc,
                            input bit strayMiss);
    chk({req, " redirect valid"}, redirectValid, 1);
    chk({req, " redirect pc"}, redirectPc, pc);
    chk({req, " tid switched"}, activeTid, tid);
    chk({req, " no stall"}, stall, 0);
    chk({req, " no flush"}, flush, 0);
    if (strayMiss) begin missValid = 1'b1; missPc = 32'hDEAD_0000; end
    step();
    missValid = 1'b0;
    chk("R3 redirect one cycle", redirectValid, 0);
    chk("R8 no flush after redirect-cycle miss", flush, 0);
  endtask

  task automatic checkStall(input logic tid, input int n);
    for (int i = 0; i < n; i++) begin
      chk("R6 stall high", stall, 1);
      chk("R6 no redirect in stall", redirectValid, 0);
      chk("R10 tid held in stall", activeTid, tid);
      if (i < n - 1) step();
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; startPc = 32'h0000_1000;
    missValid = 1'b0; missPc = '0; missRet = 2'b00;
    repeat (3) step();
    chk("R1 tid in reset", activeTid, 0);
    chk("R1 flush in reset", flush, 0);
    rst_n = 1'b1;
    step();
    chk("R1 tid after reset", activeTid, 0);
    chk("R1 flush after reset", flush, 0);
    chk("R1 stall after reset", stall, 0);
    chk("R1 redirect after reset", redirectValid, 0);
  endtask

  task automatic t_basic_switch();
    doMiss(32'h0000_2000);
    flushPhase(0, -1, 2'b00, -1, '0);
    checkRedir("R3 R1 first switch", 1, 32'h0000_1000, 0);
  endtask

  task automatic t_stall_resume();
    doMiss(32'h0000_3000);
    flushPhase(1, -1, 2'b00, -1, '0);
    checkStall(1, 3);
    pulseRet(2'b01);
    checkRedir("R6 R4 resume thread0", 0, 32'h0000_2000, 0);
  endtask

  task automatic t_ignore_miss();
    pulseRet(2'b10);
    chk("R9 idle while other returns", flush, 0);
    doMiss(32'h0000_4000);
    flushPhase(0, -1, 2'b00, 1, 32'h0000_5000);
    checkRedir("R8 R5 switch to ready thread1", 1, 32'h0000_3000, 1);
  endtask

  task automatic t_self_resume();
    doMiss(32'h0000_6000);
    flushPhase(1, 1, 2'b10, -1, '0);
    checkRedir("R5 self resume", 1, 32'h0000_6000, 0);
  endtask

  task automatic t_stray_return();
    pulseRet(2'b10);
    for (int i = 0; i < 3; i++) begin
      chk("R9 no flush", flush, 0);
      chk("R9 no stall", stall, 0);
      chk("R9 no redirect", redirectValid, 0);
      chk("R9 tid kept", activeTid, 1);
      step();
    end
  endtask

  task automatic t_both_return();
    doMiss(32'h0000_7000);
    flushPhase(1, -1, 2'b00, -1, '0);
    checkStall(1, 2);
    pulseRet(2'b11);
    checkRedir("R7 R8 tie picks thread0", 0, 32'h0000_4000, 0);
    doMiss(32'h0000_8000);
    flushPhase(0, -1, 2'b00, -1, '0);
    checkRedir("R7 thread1 left ready", 1, 32'h0000_7000, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nErrors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; startPc = '0; missValid = 1'b0; missPc = '0; missRet = 2'b00;
    step();
    t_reset();
    t_basic_switch();
    t_stall_resume();
    t_ignore_miss();
    t_self_resume();
    t_stray_return();
    t_both_return();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule